// File: doc/BRIEF.md
# Frequency Select Latch and Operating Mode Decoder

This block belongs to a motherboard clock generator. At power-good it samples a set of board straps and then holds them: three frequency-select straps and an output-current strap. The most significant select strap has three levels. An analog front end outside this block reduces each strap to a two-bit level code. The block then chooses where the 5-bit frequency code comes from. The source is either the latched straps or a code written into a configuration register. A separate divider override can stand in for both of them.

From the latched straps the block decodes the operating mode of the output buffers:
- unbuffered, where the 66 MHz group runs from the internal synthesizer;
- buffered, where the 66 MHz group follows an external 66 MHz input and PCI runs at half of that input;
- tristate, where every output floats;
- test, where the outputs run from divided copies of a test clock.

In test mode the block also produces the divided test clocks, using a binary counter that runs on the test clock.

Top module: `clkgen_fsel_decoder`

## Requirements
- R1: On every rising `clk` edge at which `pwrgd_n` is 0, the block captures all four straps. While `pwrgd_n` is 1 the latched values hold unchanged.
- R2: Each strap input uses the level code 00 = low, 01 = mid, 10 = high. The code 11 is read as high. `lat_s2` reports the normalised level (00, 01 or 10). On `s1_lvl`, `s0_lvl` and `mult_lvl` a mid reading is taken as low, so `lat_s1`, `lat_s0` and `lat_mult` are 1 only for a high reading.
- R3: When the code comes from the straps, `freq_code` takes one of three values. With the third strap low or high it is {000, lat_s1, lat_s0}, which selects 66.67, 100, 200 or 133.33 MHz. With the third strap mid and `lat_s1` = 1 it is {001, 0, lat_s0}, which selects 150/50/25 or 166.67/55.56/27.78 MHz. With the third strap mid and `lat_s1` = 0 it is 0.
- R4: With `reg_src_sel` = 1, `freq_code` equals `reg_code`. With `reg_src_sel` = 0, it is the strap code of R3.
- R5: With `div_override` = 1, `code_live` is 0 and `freq_code` reads 0, whatever the source select and the straps are. Otherwise `code_live` is 1.
- R6: `mode` comes only from the latched straps, as follows:
  - third strap low gives 00 (unbuffered);
  - third strap high gives 01 (buffered pass-through);
  - mid with lat_s1,lat_s0 = 00 gives 10 (tristate);
  - mid with 01 gives 11 (test);
  - mid with 10 or 11 gives 00.
- R7: `mode` does not depend on `reg_src_sel`, `reg_code` or `div_override`.
- R8: While `mode` is not 11, `tdiv` is all zero. After test mode is entered, the counter is released SYNC_STAGES `tclk` edges later. It then counts up by one on each rising `tclk` edge from 0, so bit k of `tdiv` is the test clock divided by 2^(k+1).
- R9: While `rst_n` is 0, all latched straps read low, `freq_code` is 0 (with `div_override` low) and `mode` is 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s2_lvl | input | 2 | Three-level select strap, level code |
| s1_lvl | input | 2 | Select strap 1, level code |
| s0_lvl | input | 2 | Select strap 0, level code |
| mult_lvl | input | 2 | Output-current strap, level code |
| pwrgd_n | input | 1 | Active-low power-good qualifier; low captures |
| reg_src_sel | input | 1 | 1 = register code, 0 = strap code |
| reg_code | input | CODE_W | Register frequency code |
| div_override | input | 1 | Divider values taken directly from registers |
| tclk | input | 1 | Test clock |
| lat_s2 | output | 2 | Latched, normalised third strap level |
| lat_s1 | output | 1 | Latched select strap 1 |
| lat_s0 | output | 1 | Latched select strap 0 |
| lat_mult | output | 1 | Latched output-current strap |
| freq_code | output | CODE_W | Effective frequency code |
| code_live | output | 1 | Frequency code is in use (no override) |
| mode | output | 2 | Operating mode: 00 unbuffered, 01 buffered, 10 tristate, 11 test |
| tdiv | output | DIV_W | Test clock divided by 2, 4, 8 ... |

## Verification
The bench builds the block with its defaults: CODE_W = 5, DIV_W = 3 and SYNC_STAGES = 2. With these values the strap space is small enough to sweep in full. All 256 combinations of the four two-bit level codes are latched and checked, including the 11 code and the mid reading on two-level straps. All 32 register codes are swept against a fixed strap setting. A three-bit test counter wraps within a few test-clock periods, so its release from zero and its modulo-8 wrap can both be observed directly.

// File: rtl/clkgen_fsel_pkg.sv
package clkgen_fsel_pkg;

   typedef enum logic [1:0] {
      LVL_LOW  = 2'b00,
      LVL_MID  = 2'b01,
      LVL_HIGH = 2'b10
   } lvl_e;

   typedef enum logic [1:0] {
      MODE_UNBUF = 2'b00,
      MODE_BUF   = 2'b01,
      MODE_HIZ   = 2'b10,
      MODE_TEST  = 2'b11
   } mode_e;

   // three-level reading: code 11 is taken as high
   function automatic lvl_e norm_lvl(input logic [1:0] raw);
      if (raw[1])      return LVL_HIGH;
      else if (raw[0]) return LVL_MID;
      else             return LVL_LOW;
   endfunction

   // two-level reading: mid collapses to low
   function automatic logic two_lvl(input logic [1:0] raw);
      return raw[1];
   endfunction

endpackage

// File: rtl/clkgen_fsel_strap_latch.sv
module clkgen_fsel_strap_latch
   import clkgen_fsel_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pwrgd_n,
   input  logic [1:0] s2_lvl,
   input  logic [1:0] s1_lvl,
   input  logic [1:0] s0_lvl,
   input  logic [1:0] mult_lvl,
   output lvl_e       lat_s2,
   output logic       lat_s1,
   output logic       lat_s0,
   output logic       lat_mult
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lat_s2   <= LVL_LOW;
         lat_s1   <= 1'b0;
         lat_s0   <= 1'b0;
         lat_mult <= 1'b0;
      end else if (!pwrgd_n) begin
         lat_s2   <= norm_lvl(s2_lvl);
         lat_s1   <= two_lvl(s1_lvl);
         lat_s0   <= two_lvl(s0_lvl);
         lat_mult <= two_lvl(mult_lvl);
      end
   end

endmodule

// File: rtl/clkgen_fsel_mode_decode.sv
module clkgen_fsel_mode_decode
   import clkgen_fsel_pkg::*;
#(
   parameter int CODE_W = 5
) (
   input  lvl_e              lat_s2,
   input  logic              lat_s1,
   input  logic              lat_s0,
   input  logic              reg_src_sel,
   input  logic [CODE_W-1:0] reg_code,
   input  logic              div_override,
   output logic [CODE_W-1:0] freq_code,
   output logic              code_live,
   output mode_e             mode
);

   localparam int PAD_W = CODE_W - 3;

   logic [CODE_W-1:0] strap_code;
   logic [CODE_W-1:0] sel_code;

   // strap-derived code: table rows 0..3 for low/high, rows 4/5 for mid,1x
   always_comb begin
      strap_code = '0;
      unique case (lat_s2)
         LVL_MID: begin
            if (lat_s1) strap_code = {{PAD_W{1'b0}}, 1'b1, 1'b0, lat_s0};
         end
         default: strap_code = {{PAD_W{1'b0}}, 1'b0, lat_s1, lat_s0};
      endcase
   end

   assign sel_code  = reg_src_sel ? reg_code : strap_code;
   assign code_live = ~div_override;
   assign freq_code = div_override ? '0 : sel_code;

   always_comb begin
      mode = MODE_UNBUF;
      unique case (lat_s2)
         LVL_HIGH: mode = MODE_BUF;
         LVL_MID: begin
            if (!lat_s1) mode = lat_s0 ? MODE_TEST : MODE_HIZ;
         end
         default: mode = MODE_UNBUF;
      endcase
   end

endmodule

// File: rtl/clkgen_fsel_test_div.sv
module clkgen_fsel_test_div #(
   parameter int DIV_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic             tclk,
   input  logic             run,
   output logic [DIV_W-1:0] tdiv
);

   logic             release_n;
   logic [DIV_W-1:0] cnt;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign release_n = run;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sy;
         always_ff @(posedge tclk or negedge run) begin
            if (!run) begin
               sy <= '0;
            end else begin
               sy[0] <= 1'b1;
               for (int i = 1; i < SYNC_STAGES; i++) sy[i] <= sy[i-1];
            end
         end
         assign release_n = sy[SYNC_STAGES-1];
      end
   endgenerate

   always_ff @(posedge tclk or negedge release_n) begin
      if (!release_n) cnt <= '0;
      else            cnt <= cnt + 1'b1;
   end

   assign tdiv = cnt;

endmodule

// File: rtl/clkgen_fsel_decoder.sv
module clkgen_fsel_decoder
   import clkgen_fsel_pkg::*;
#(
   parameter int CODE_W      = 5,
   parameter int DIV_W       = 3,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        s2_lvl,
   input  logic [1:0]        s1_lvl,
   input  logic [1:0]        s0_lvl,
   input  logic [1:0]        mult_lvl,
   input  logic              pwrgd_n,
   input  logic              reg_src_sel,
   input  logic [CODE_W-1:0] reg_code,
   input  logic              div_override,
   input  logic              tclk,
   output logic [1:0]        lat_s2,
   output logic              lat_s1,
   output logic              lat_s0,
   output logic              lat_mult,
   output logic [CODE_W-1:0] freq_code,
   output logic              code_live,
   output logic [1:0]        mode,
   output logic [DIV_W-1:0]  tdiv
);

   generate
      if (CODE_W < 3) begin : g_bad_code_w
         $error("CODE_W must be at least 3");
      end
      if (DIV_W < 1) begin : g_bad_div_w
         $error("DIV_W must be at least 1");
      end
      if (SYNC_STAGES < 0) begin : g_bad_sync
         $error("SYNC_STAGES must not be negative");
      end
   endgenerate

   lvl_e  s2_q;
   mode_e mode_d;
   logic  test_run;

   clkgen_fsel_strap_latch u_latch (
      .clk      (clk),
      .rst_n    (rst_n),
      .pwrgd_n  (pwrgd_n),
      .s2_lvl   (s2_lvl),
      .s1_lvl   (s1_lvl),
      .s0_lvl   (s0_lvl),
      .mult_lvl (mult_lvl),
      .lat_s2   (s2_q),
      .lat_s1   (lat_s1),
      .lat_s0   (lat_s0),
      .lat_mult (lat_mult)
   );

   clkgen_fsel_mode_decode #(.CODE_W(CODE_W)) u_decode (
      .lat_s2       (s2_q),
      .lat_s1       (lat_s1),
      .lat_s0       (lat_s0),
      .reg_src_sel  (reg_src_sel),
      .reg_code     (reg_code),
      .div_override (div_override),
      .freq_code    (freq_code),
      .code_live    (code_live),
      .mode         (mode_d)
   );

   assign test_run = rst_n && (mode_d == MODE_TEST);

   clkgen_fsel_test_div #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_tdiv (
      .tclk (tclk),
      .run  (test_run),
      .tdiv (tdiv)
   );

   assign lat_s2 = s2_q;
   assign mode   = mode_d;

endmodule

// File: rtl/clkgen_fsel_decoder_chk.sv
module clkgen_fsel_decoder_chk #(
   parameter int CODE_W = 5,
   parameter int DIV_W  = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [1:0]        s2_lvl,
   input logic [1:0]        s1_lvl,
   input logic [1:0]        s0_lvl,
   input logic [1:0]        mult_lvl,
   input logic              pwrgd_n,
   input logic              reg_src_sel,
   input logic [CODE_W-1:0] reg_code,
   input logic              div_override,
   input logic [1:0]        lat_s2,
   input logic              lat_s1,
   input logic              lat_s0,
   input logic              lat_mult,
   input logic [CODE_W-1:0] freq_code,
   input logic              code_live,
   input logic [1:0]        mode,
   input logic [DIV_W-1:0]  tdiv
);

   logic past_ok;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   assert_strap_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && $past(pwrgd_n) |->
         $stable(lat_s2) && $stable(lat_s1) && $stable(lat_s0) && $stable(lat_mult));

   // R2: high level bit decides the two-level reading
   assert_strap_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok && !$past(pwrgd_n) |->
         lat_s2[1] == $past(s2_lvl[1]) && lat_s1 == $past(s1_lvl[1]) &&
         lat_s0 == $past(s0_lvl[1]) && lat_mult == $past(mult_lvl[1]));

   assert_strap_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      code_live && !reg_src_sel && lat_s2 == 2'b00 |->
         freq_code == {{(CODE_W-2){1'b0}}, lat_s1, lat_s0});

   assert_reg_code_R4: assert property (@(posedge clk) disable iff (!rst_n)
      code_live && reg_src_sel |-> freq_code == reg_code);

   assert_override_R5: assert property (@(posedge clk) disable iff (!rst_n)
      div_override |-> !code_live && freq_code == '0);

   assert_tristate_R6: assert property (@(posedge clk) disable iff (!rst_n)
      lat_s2 == 2'b01 && !lat_s1 && !lat_s0 |-> mode == 2'b10);

   assert_tdiv_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      mode != 2'b11 |-> tdiv == '0);

endmodule

bind clkgen_fsel_decoder clkgen_fsel_decoder_chk #(.CODE_W(CODE_W), .DIV_W(DIV_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .s2_lvl       (s2_lvl),
   .s1_lvl       (s1_lvl),
   .s0_lvl       (s0_lvl),
   .mult_lvl     (mult_lvl),
   .pwrgd_n      (pwrgd_n),
   .reg_src_sel  (reg_src_sel),
   .reg_code     (reg_code),
   .div_override (div_override),
   .lat_s2       (lat_s2),
   .lat_s1       (lat_s1),
   .lat_s0       (lat_s0),
   .lat_mult     (lat_mult),
   .freq_code    (freq_code),
   .code_live    (code_live),
   .mode         (mode),
   .tdiv         (tdiv)
);

// File: tb/clkgen_fsel_decoder_tb_top.sv
`timescale 1ns/1ps
module clkgen_fsel_decoder_tb_top;

   localparam int CODE_W = 5;
   localparam int DIV_W  = 3;

   logic              clk = 1'b0;
   logic              tclk = 1'b0;
   logic              rst_n = 1'b0;
   logic [1:0]        s2_lvl = 2'b00, s1_lvl = 2'b00, s0_lvl = 2'b00, mult_lvl = 2'b00;
   logic              pwrgd_n = 1'b1;
   logic              reg_src_sel = 1'b0;
   logic [CODE_W-1:0] reg_code = '0;
   logic              div_override = 1'b0;
   logic [1:0]        lat_s2;
   logic              lat_s1, lat_s0, lat_mult;
   logic [CODE_W-1:0] freq_code;
   logic              code_live;
   logic [1:0]        mode;
   logic [DIV_W-1:0]  tdiv;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;
   always #5 tclk = ~tclk;

   clkgen_fsel_decoder #(.CODE_W(CODE_W), .DIV_W(DIV_W), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .s2_lvl(s2_lvl), .s1_lvl(s1_lvl), .s0_lvl(s0_lvl),
      .mult_lvl(mult_lvl), .pwrgd_n(pwrgd_n), .reg_src_sel(reg_src_sel),
      .reg_code(reg_code), .div_override(div_override), .tclk(tclk),
      .lat_s2(lat_s2), .lat_s1(lat_s1), .lat_s0(lat_s0), .lat_mult(lat_mult),
      .freq_code(freq_code), .code_live(code_live), .mode(mode), .tdiv(tdiv)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int e_lvl(input logic [1:0] r);
      return (r >= 2) ? 2 : int'(r);
   endfunction
   function automatic int e_bit(input logic [1:0] r);
      return (r >= 2) ? 1 : 0;
   endfunction
   function automatic int e_code(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
      int l2 = e_lvl(a);
      int b1 = e_bit(b);
      int b0 = e_bit(c);
      if (l2 != 1) return b1 * 2 + b0;
      return b1 ? 4 + b0 : 0;
   endfunction
   function automatic int e_mode(input logic [1:0] a, input logic [1:0] b, input logic [1:0] c);
      int l2 = e_lvl(a);
      if (l2 == 0) return 0;
      if (l2 == 2) return 1;
      if (e_bit(b) == 1) return 0;
      return e_bit(c) ? 3 : 2;
   endfunction

   task automatic latch_straps(input logic [1:0] a, input logic [1:0] b,
                               input logic [1:0] c, input logic [1:0] m);
      @(negedge clk);
      s2_lvl = a; s1_lvl = b; s0_lvl = c; mult_lvl = m; pwrgd_n = 1'b0;
      @(negedge clk);
      pwrgd_n = 1'b1;
   endtask

   initial begin
      // R9 reset state
      #11;
      @(negedge clk);
      check("R9 lat_s2", lat_s2, 0);
      check("R9 lat bits", {lat_s1, lat_s0, lat_mult}, 0);
      check("R9 freq_code", freq_code, 0);
      check("R9 mode", mode, 0);
      check("R8 tdiv idle in reset", tdiv, 0);
      rst_n = 1'b1;

      // R1/R2/R3/R6: exhaustive strap sweep
      for (int i = 0; i < 256; i++) begin
         logic [7:0] v = i[7:0];
         latch_straps(v[7:6], v[5:4], v[3:2], v[1:0]);
         check("R2 lat_s2", lat_s2, e_lvl(v[7:6]));
         check("R2 lat_s1/s0/mult", {lat_s1, lat_s0, lat_mult},
               e_bit(v[5:4]) * 4 + e_bit(v[3:2]) * 2 + e_bit(v[1:0]));
         check("R3 strap code", freq_code, e_code(v[7:6], v[5:4], v[3:2]));
         check("R6 mode", mode, e_mode(v[7:6], v[5:4], v[3:2]));
         check("R5 code_live", code_live, 1);
      end

      // R1 hold: straps move with pwrgd_n high
      latch_straps(2'b10, 2'b10, 2'b00, 2'b10);
      @(negedge clk);
      s2_lvl = 2'b01; s1_lvl = 2'b00; s0_lvl = 2'b10; mult_lvl = 2'b00;
      repeat (3) @(negedge clk);
      check("R1 hold lat_s2", lat_s2, 2);
      check("R1 hold bits", {lat_s1, lat_s0, lat_mult}, 5);
      check("R1 hold code", freq_code, 2);
      check("R1 hold mode", mode, 1);

      // R4/R7: register source sweep with a mid,10 strap setting
      latch_straps(2'b01, 2'b10, 2'b00, 2'b00);
      check("R3 mid,10 code", freq_code, 4);
      reg_src_sel = 1'b1;
      for (int c = 0; c < 32; c++) begin
         reg_code = c[4:0];
         @(negedge clk);
         check("R4 register code", freq_code, c);
         check("R7 mode unaffected", mode, 0);
      end
      reg_src_sel = 1'b0;
      @(negedge clk);
      check("R4 back to straps", freq_code, 4);

      // R5 override under both sources
      for (int s = 0; s < 2; s++) begin
         reg_src_sel = s[0];
         reg_code = 5'd19;
         div_override = 1'b1;
         @(negedge clk);
         check("R5 freq_code forced", freq_code, 0);
         check("R5 code_live", code_live, 0);
         check("R7 mode with override", mode, 0);
      end
      div_override = 1'b0;
      reg_src_sel = 1'b0;

      // R8: test divider
      latch_straps(2'b01, 2'b00, 2'b10, 2'b00);
      check("R6 test mode", mode, 3);
      begin
         int prev = 0;
         bit started = 0;
         bit saw_zero = 0;
         for (int k = 0; k < 40; k++) begin
            @(negedge tclk);
            if (!started) begin
               if (tdiv == 0) saw_zero = 1;
               else begin
                  check("R8 first count after release", tdiv, 1);
                  started = 1;
               end
            end else begin
               check("R8 count step", tdiv, (prev + 1) % 8);
            end
            prev = int'(tdiv);
         end
         check("R8 counter started from zero", saw_zero, 1);
         check("R8 counter running", started, 1);
      end
      latch_straps(2'b01, 2'b00, 2'b00, 2'b00);
      check("R6 tristate", mode, 2);
      check("R8 tdiv cleared outside test", tdiv, 0);
      repeat (10) @(negedge clk);
      check("R8 tdiv stays idle", tdiv, 0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule